// File: doc/BRIEF.md
# Buffer Write Interrupt Pulse Generator

This block sits beside a shared byte buffer that internal logic fills while a host reads it. Each time the internal side writes a byte, the block captures that byte's address and, after a fixed delay, drives a fixed-width active-low interrupt pulse. A host that reacts to the pulse can read the captured address. From it the host knows which byte was just refreshed and which byte the internal pointer will touch next. It can then sweep the whole buffer starting just behind the writer and never collide with an internal update.

All timing is counted in periods of the serial bit clock, which runs at 64 times the incoming sample rate. With the default parameters the pulse starts in the fifth clock period after the write and lasts four periods. If a new write lands while a pulse is still pending or under way, the timing restarts for the newest write. The buffer RAM and the host bus are outside this block.

Top module: `wr_irq_pulser`

## Requirements
- R1: While reset is high and in the first cycle after it is released, irqN is 1, lastAddr is 0 and nextAddr is 1.
- R2: When wrEn is 1 at a rising clock edge, lastAddr shows the wrAddr sampled at that edge from the next cycle on. It holds that value until the next write.
- R3: nextAddr equals lastAddr + 1, except that it is 0 when lastAddr is BUF_DEPTH-1 (23 by default).
- R4: irqN is active low. If the write strobe is high in cycle T and no further write follows, irqN first reads 0 in cycle T+IRQ_DELAY (T+5 by default).
- R5: Without a further write, irqN stays 0 for exactly IRQ_WIDTH cycles (4 by default) and then returns to 1 until the next write.
- R6: With no write since reset, irqN stays 1.
- R7: A write in cycle T' restarts the timing, whether a pulse is pending or already low. irqN is 1 in cycle T'+1, and the pulse follows R4 and R5 measured from T'.
- R8: If writes arrive in every cycle, irqN stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Internal buffer write strobe |
| wrAddr | input | ADDR_W | Byte address being written |
| irqN | output | 1 | Active-low interrupt pulse |
| lastAddr | output | ADDR_W | Address of the byte most recently written |
| nextAddr | output | ADDR_W | Address the internal pointer writes next (wraps at BUF_DEPTH) |

## Verification
The two functions that can fall in the same cycle are a new capture and the delayed pulse of an earlier write. The new write must cut the old pulse off at once and restart the delay. The bench provokes this with directed writes placed while a pulse is pending and while it is low, and with a burst of writes in every cycle. It adds random write traffic that places writes at every phase of the pulse. In each cycle a bench model keyed only to the number of cycles since the last write predicts irqN, and this prediction is compared with the pin together with both address outputs.

// File: rtl/wr_irq_pkg.sv
package wr_irq_pkg;

  // Strobes passed from the timing control to the datapath.
  typedef struct packed {
    logic captureAddr;  // latch the write address this edge
    logic driveLow;     // interrupt line should read low after this edge
  } irqStrobes_t;

endpackage

// File: rtl/wr_irq_ctrl.sv
module wr_irq_ctrl
  import wr_irq_pkg::*;
#(
  parameter int IRQ_DELAY = 5,
  parameter int IRQ_WIDTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  output irqStrobes_t strobes
);

  localparam int LAST_AGE_I = IRQ_DELAY + IRQ_WIDTH - 1;
  localparam int AGE_W      = $clog2(LAST_AGE_I + 2);
  localparam logic [AGE_W-1:0] AGE_ONE  = AGE_W'(1);
  localparam logic [AGE_W-1:0] AGE_LOW  = AGE_W'(IRQ_DELAY);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(LAST_AGE_I);

  logic             active, activeNext;
  logic [AGE_W-1:0] age, ageNext;

  // age counts cycles since the newest write; a write always restarts it.
  always_comb begin
    activeNext = active;
    ageNext    = age;
    if (wrEn) begin
      activeNext = 1'b1;
      ageNext    = AGE_ONE;
    end else if (active) begin
      if (age == AGE_LAST) begin
        activeNext = 1'b0;
        ageNext    = '0;
      end else begin
        ageNext = age + AGE_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      age    <= '0;
    end else begin
      active <= activeNext;
      age    <= ageNext;
    end
  end

  always_comb begin
    strobes.captureAddr = wrEn;
    strobes.driveLow    = activeNext && (ageNext >= AGE_LOW) && (ageNext <= AGE_LAST);
  end

  // R5: the timing window closes after the last low cycle when no write interrupts it
  assert_window_close_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !wrEn && age == AGE_LAST) |=> !active);

  // R7: the age is bounded whenever a window is open
  assert_age_bound_R7: assert property (@(posedge clk) disable iff (rst)
    active |-> (age >= AGE_ONE && age <= AGE_LAST));

endmodule

// File: rtl/wr_irq_datapath.sv
module wr_irq_datapath
  import wr_irq_pkg::*;
#(
  parameter int BUF_DEPTH = 24,
  parameter int ADDR_W    = 5,
  parameter int IRQ_DELAY = 5,
  parameter int IRQ_WIDTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  irqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              irqN,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [ADDR_W-1:0] nextAddr
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(BUF_DEPTH - 1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  // Address capture and pointer look-ahead.
  always_ff @(posedge clk) begin
    if (rst) begin
      lastAddr <= '0;
      nextAddr <= ADDR_ONE;
    end else if (strobes.captureAddr) begin
      lastAddr <= wrAddr;
      nextAddr <= (wrAddr == ADDR_TOP) ? '0 : wrAddr + ADDR_ONE;
    end
  end

  // Registered interrupt line, idle high.
  always_ff @(posedge clk) begin
    if (rst) irqN <= 1'b1;
    else     irqN <= !strobes.driveLow;
  end

  // Checker state: cycles since the last capture, and length of the current low run.
  localparam int SAT_I  = IRQ_DELAY + IRQ_WIDTH + 1;
  localparam int CHK_W  = $clog2(SAT_I + 1);
  localparam logic [CHK_W-1:0] CHK_SAT = CHK_W'(SAT_I);
  localparam logic [CHK_W-1:0] CHK_ONE = CHK_W'(1);

  logic [CHK_W-1:0] sinceCap;
  logic [CHK_W-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceCap <= '0;
      lowRun   <= '0;
    end else begin
      if (strobes.captureAddr)                      sinceCap <= CHK_ONE;
      else if (sinceCap != '0 && sinceCap != CHK_SAT) sinceCap <= sinceCap + CHK_ONE;
      if (!irqN && lowRun != CHK_SAT) lowRun <= lowRun + CHK_ONE;
      else if (irqN)                  lowRun <= '0;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.captureAddr |=> lastAddr == $past(wrAddr));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.captureAddr |=> ($stable(lastAddr) && $stable(nextAddr)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (lastAddr == ADDR_TOP) |-> (nextAddr == '0));

  assert_fall_delay_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irqN) |-> (sinceCap == CHK_W'(IRQ_DELAY)));

  assert_low_width_R5: assert property (@(posedge clk) disable iff (rst)
    lowRun <= CHK_W'(IRQ_WIDTH));

  assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (sinceCap == '0) |-> irqN);

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.captureAddr |=> irqN);

endmodule

// File: rtl/wr_irq_pulser.sv
module wr_irq_pulser
  import wr_irq_pkg::*;
#(
  parameter int BUF_DEPTH = 24,
  parameter int IRQ_DELAY = 5,
  parameter int IRQ_WIDTH = 4,
  parameter int ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              irqN,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [ADDR_W-1:0] nextAddr
);

  irqStrobes_t strobes;

  wr_irq_ctrl #(
    .IRQ_DELAY(IRQ_DELAY),
    .IRQ_WIDTH(IRQ_WIDTH)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .strobes(strobes)
  );

  wr_irq_datapath #(
    .BUF_DEPTH(BUF_DEPTH),
    .ADDR_W   (ADDR_W),
    .IRQ_DELAY(IRQ_DELAY),
    .IRQ_WIDTH(IRQ_WIDTH)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .irqN    (irqN),
    .lastAddr(lastAddr),
    .nextAddr(nextAddr)
  );

endmodule

// File: tb/wr_irq_pulser_test.sv
`timescale 1ns/1ps
module wr_irq_pulser_test;

  localparam int BUF_DEPTH = 24;
  localparam int IRQ_DELAY = 5;
  localparam int IRQ_WIDTH = 4;
  localparam int ADDR_W    = $clog2(BUF_DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic              irqN;
  logic [ADDR_W-1:0] lastAddr, nextAddr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state from the requirements
  int since   = 0;  // cycles since newest write, 0 = none yet
  int expLast = 0;

  always #2 clk = ~clk;

  wr_irq_pulser #(
    .BUF_DEPTH(BUF_DEPTH),
    .IRQ_DELAY(IRQ_DELAY),
    .IRQ_WIDTH(IRQ_WIDTH)
  ) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .irqN(irqN), .lastAddr(lastAddr), .nextAddr(nextAddr)
  );

  function automatic logic expIrq(int s);
    return !(s >= IRQ_DELAY && s < IRQ_DELAY + IRQ_WIDTH);
  endfunction

  function automatic int expNext(int a);
    return (a == BUF_DEPTH - 1) ? 0 : a + 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string irqTag);
    check(irqTag, int'(irqN), int'(expIrq(since)), "irqN");
    check("R2", int'(lastAddr), expLast, "lastAddr");
    check("R3", int'(nextAddr), expNext(expLast), "nextAddr");
  endtask

  // called at a negedge: drive, pass one rising edge, update model, sample at next negedge
  task automatic cycle(bit we, int addr, string irqTag);
    wrEn   = we;
    wrAddr = ADDR_W'(addr);
    @(posedge clk);
    if (we) begin
      since   = 1;
      expLast = addr;
    end else if (since != 0 && since < 1000) begin
      since++;
    end
    @(negedge clk);
    checkAll(irqTag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lowCount;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'(irqN), 1, "irqN in reset");
    check("R1", int'(lastAddr), 0, "lastAddr in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(irqN), 1, "irqN after reset");
    check("R1", int'(lastAddr), 0, "lastAddr after reset");
    check("R1", int'(nextAddr), 1, "nextAddr after reset");

    // idle: no pulse ever
    for (int i = 0; i < 20; i++) cycle(1'b0, 0, "R6");

    // single write: fall at T+5, low 4 cycles
    cycle(1'b1, 7, "R4");
    lowCount = 0;
    for (int i = 2; i <= 14; i++) begin
      cycle(1'b0, 0, (i < 9) ? "R4" : "R5");
      if (i == IRQ_DELAY) check("R4", int'(irqN), 0, "first low cycle");
      if (i == IRQ_DELAY - 1) check("R4", int'(irqN), 1, "cycle before low");
      if (!irqN) lowCount++;
    end
    check("R5", lowCount, IRQ_WIDTH, "low cycle count");

    // wrap of the look-ahead pointer
    cycle(1'b1, BUF_DEPTH - 1, "R3");
    check("R3", int'(nextAddr), 0, "nextAddr wrap");
    for (int i = 0; i < 12; i++) cycle(1'b0, 0, "R5");

    // restart during pending delay
    cycle(1'b1, 3, "R7");
    for (int i = 0; i < 2; i++) cycle(1'b0, 0, "R7");
    cycle(1'b1, 4, "R7");
    check("R7", int'(irqN), 1, "high after restart while pending");
    for (int i = 0; i < 12; i++) cycle(1'b0, 0, "R7");

    // restart while the line is low
    cycle(1'b1, 10, "R7");
    for (int i = 0; i < 5; i++) cycle(1'b0, 0, "R7");
    check("R7", int'(irqN), 0, "low before restart");
    cycle(1'b1, 11, "R7");
    check("R7", int'(irqN), 1, "high right after restart");
    check("R2", int'(lastAddr), 11, "new address captured");
    for (int i = 0; i < 12; i++) cycle(1'b0, 0, "R7");

    // writes every cycle
    for (int i = 0; i < 30; i++) begin
      cycle(1'b1, i % BUF_DEPTH, "R8");
      check("R8", int'(irqN), 1, "burst keeps line high");
    end
    for (int i = 0; i < 12; i++) cycle(1'b0, 0, "R5");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit we;
      int a;
      we = (($urandom % 9) == 0);
      a  = int'($urandom % BUF_DEPTH);
      cycle(we, a, "R4");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule